// File: doc/BRIEF.md
# DDR Extended Mode Register Sequencer

This block sits on the controller side of a DDR SDRAM interface. It programs the extended mode register and then manages the DLL start-up that follows. When a request is accepted, it latches the DLL setting, the drive-strength choice and a base operating-mode word. It then waits until every bank is idle and no burst is in flight. Only then does it issue a LOAD MODE REGISTER command to the extended register.

When the DLL is being enabled, a base mode register load with the DLL-reset bit set follows the extended load. Every load is followed by a parameterised run of NOP cycles.

A separate lockout timer raises a read-inhibit flag for a fixed number of cycles after each DLL enable. The same timer also restarts on every self-refresh exit, with no register load involved. The controller uses `ready_o` to know when it may start a new sequence. It uses `rd_inhibit_o` to hold back READ commands.

Top module: `emr_seq`

## Requirements
- R1: While `rst_ni` is low and right after release: `cmd_o` is NOP (3'b111), `ba_o` and `addr_o` are 0, `ready_o` is 1, and `rd_inhibit_o` and `err_o` are 0.
- R2: A request sampled with `ready_o` high produces an extended load in the second cycle after the sampling edge, provided the preconditions already hold. The extended load is `cmd_o`=3'b000 with `ba_o`=2'b01. Its address carries `addr_o[0]`=`dll_off_i` (0 enables the DLL), `addr_o[1]`=reduced drive, and `addr_o[12:2]`=0.
- R3: The extended load is held off while `banks_idle_i` is low or `burst_busy_i` is high. It appears in the cycle after the first edge at which both conditions are met.
- R4: Each mode register load is followed by exactly `MRD_GAP` (default 2) NOP cycles before the next command of the same sequence.
- R5: With the DLL enabled, the extended load is followed by a base load: `cmd_o`=3'b000, `ba_o`=2'b00, `addr_o`= latched base word with bit 8 (DLL reset) forced to 1. With the DLL disabled, no base load is issued. `ready_o` returns 2*(MRD_GAP+1)+1 cycles after the request cycle with the DLL enabled, and MRD_GAP+2 cycles after it with the DLL disabled.
- R6: An extended load that enables the DLL makes `rd_inhibit_o` high for exactly `LOCK_CYCLES` (default 200) cycles, starting the cycle after the load. A load that disables the DLL starts no lockout.
- R7: A pulse on `sr_exit_i` makes `rd_inhibit_o` high for exactly `LOCK_CYCLES` cycles, starting the next cycle. A pulse during a running lockout restarts the count. No command is issued.
- R8: A request sampled while `ready_o` is low gives a one-cycle `err_o` pulse in the next cycle. It has no effect on the running sequence.
- R9: `ba_o` and `addr_o` are 0 in every cycle in which `cmd_o` is NOP.
- R10: Reduced drive (`addr_o[1]`=1 on the extended load) is emitted only when `WIDE_X16`=1. With `WIDE_X16`=0, that bit is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a programming sequence |
| dll_off_i | input | 1 | 1 = disable DLL, 0 = enable DLL |
| drv_reduced_i | input | 1 | Request reduced output drive |
| base_mode_i | input | ADDR_W | Base operating-mode word for the DLL-reset load |
| banks_idle_i | input | 1 | All banks are idle |
| burst_busy_i | input | 1 | A burst is in progress |
| sr_exit_i | input | 1 | Self-refresh exit pulse |
| cmd_o | output | 3 | Command {ras_n, cas_n, we_n}: 3'b000 load, 3'b111 NOP |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| ready_o | output | 1 | Sequencer idle, a request will be accepted |
| rd_inhibit_o | output | 1 | READ commands must not be issued |
| err_o | output | 1 | Request rejected because a sequence was running |

## Verification
Several rules are checked by the assertions on every cycle:
- every load is immediately followed by a NOP, and bus fields are quiet outside loads;
- the extended load only follows a cycle with all banks idle and no burst, and its reserved bits are zero;
- the base load carries the DLL-reset bit;
- a DLL enable or a self-refresh exit raises the read inhibit in the next cycle, and a busy-time request flags an error.

Other properties need the bench's scenarios:
- the exact length of the lockout and its restart;
- the hold-off cycle count;
- the total sequence length for each DLL setting;
- the command order and contents delivered to the scoreboard;
- that an ignored request leaves the latched settings untouched.

// File: rtl/emr_pkg.sv
package emr_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_EXT,
    ST_GAP_EXT,
    ST_BASE,
    ST_GAP_BASE
  } seq_state_e;

endpackage

// File: rtl/emr_fsm.sv
module emr_fsm
  import emr_pkg::*;
#(
  parameter int unsigned MRD_GAP = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       cond_ok_i,
  input  logic       dll_en_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       err_o
);
  localparam int unsigned GAP_W = (MRD_GAP > 1) ? $clog2(MRD_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MRD_GAP - 1);

  seq_state_e       st_q, st_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_done;
  logic             err_q;

  assign gap_done = (gap_q == '0);
  assign accept_o = req_i && (st_q == ST_IDLE);

  always_comb begin
    st_d  = st_q;
    gap_d = gap_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_HOLD;
      ST_HOLD: if (cond_ok_i) st_d = ST_EXT;
      ST_EXT: begin
        st_d  = ST_GAP_EXT;
        gap_d = GAP_LOAD;
      end
      ST_GAP_EXT: begin
        if (gap_done) st_d = dll_en_i ? ST_BASE : ST_IDLE;
        else gap_d = gap_q - 1'b1;
      end
      ST_BASE: begin
        st_d  = ST_GAP_BASE;
        gap_d = GAP_LOAD;
      end
      ST_GAP_BASE: begin
        if (gap_done) st_d = ST_IDLE;
        else gap_d = gap_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
      err_q <= req_i && (st_q != ST_IDLE);
    end
  end

  assign state_o = st_q;
  assign err_o   = err_q;
endmodule

// File: rtl/emr_cmd_fmt.sv
module emr_cmd_fmt
  import emr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter bit          WIDE_X16    = 1'b1,
  parameter int unsigned DLL_RST_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dll_off_i,
  input  logic              drv_reduced_i,
  input  logic [ADDR_W-1:0] base_mode_i,
  input  seq_state_e        state_i,
  output logic              dll_en_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);
  localparam logic [BA_W-1:0] BA_BASE = '0;

  logic              dll_off_q;
  logic [ADDR_W-1:0] base_q;
  logic              red_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_off_q <= 1'b0;
      base_q    <= '0;
    end else if (load_i) begin
      dll_off_q <= dll_off_i;
      base_q    <= base_mode_i;
    end
  end

  generate
    if (WIDE_X16) begin : g_red
      logic red_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) red_q <= 1'b0;
        else if (load_i) red_q <= drv_reduced_i;
      end
      assign red_eff = red_q;
    end else begin : g_nored
      // narrow parts: reduced drive is never requested
      assign red_eff = 1'b0;
    end
  endgenerate

  assign dll_en_o = !dll_off_q;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (state_i)
      ST_EXT: begin
        cmd_o     = CMD_LMR;
        ba_o      = BA_EXT;
        addr_o[0] = dll_off_q;
        addr_o[1] = red_eff;
      end
      ST_BASE: begin
        cmd_o               = CMD_LMR;
        ba_o                = BA_BASE;
        addr_o              = base_q;
        addr_o[DLL_RST_BIT] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/emr_lock_timer.sv
module emr_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic inhibit_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(LOCK_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign inhibit_o = (cnt_q != '0);
endmodule

// File: rtl/emr_seq.sv
module emr_seq
  import emr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned MRD_GAP     = 2,
  parameter int unsigned LOCK_CYCLES = 200,
  parameter bit          WIDE_X16    = 1'b1,
  parameter int unsigned DLL_RST_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dll_off_i,
  input  logic              drv_reduced_i,
  input  logic [ADDR_W-1:0] base_mode_i,
  input  logic              banks_idle_i,
  input  logic              burst_busy_i,
  input  logic              sr_exit_i,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              rd_inhibit_o,
  output logic              err_o
);
  seq_state_e state;
  logic       accept;
  logic       dll_en;
  logic       lock_start;

  emr_fsm #(.MRD_GAP(MRD_GAP)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .cond_ok_i (banks_idle_i && !burst_busy_i),
    .dll_en_i  (dll_en),
    .state_o   (state),
    .accept_o  (accept),
    .err_o     (err_o)
  );

  emr_cmd_fmt #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .WIDE_X16    (WIDE_X16),
    .DLL_RST_BIT (DLL_RST_BIT)
  ) i_fmt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (accept),
    .dll_off_i     (dll_off_i),
    .drv_reduced_i (drv_reduced_i),
    .base_mode_i   (base_mode_i),
    .state_i       (state),
    .dll_en_o      (dll_en),
    .cmd_o         (cmd_o),
    .ba_o          (ba_o),
    .addr_o        (addr_o)
  );

  // lockout restarts on each DLL enable and on self-refresh exit
  assign lock_start = ((state == ST_EXT) && dll_en) || sr_exit_i;

  emr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (lock_start),
    .inhibit_o (rd_inhibit_o)
  );

  assign ready_o = (state == ST_IDLE);
endmodule

// File: rtl/emr_seq_chk.sv
module emr_seq_chk #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter bit          WIDE_X16    = 1'b1,
  parameter int unsigned DLL_RST_BIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              banks_idle_i,
  input logic              burst_busy_i,
  input logic              sr_exit_i,
  input logic [2:0]        cmd_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ready_o,
  input logic              rd_inhibit_o,
  input logic              err_o
);
  logic is_lmr, is_ext, is_base;
  assign is_lmr  = (cmd_o == 3'b000);
  assign is_ext  = is_lmr && (ba_o == BA_W'(1));
  assign is_base = is_lmr && (ba_o == '0);

  a_r3_bank_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> $past(banks_idle_i && !burst_busy_i));

  a_r2_ext_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> (addr_o[ADDR_W-1:2] == '0));

  a_r4_nop_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr |=> (cmd_o == 3'b111));

  a_r5_dll_reset_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_base |-> addr_o[DLL_RST_BIT]);

  a_r6_lock_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ext && !addr_o[0]) |=> rd_inhibit_o);

  a_r7_lock_on_srx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_i |=> rd_inhibit_o);

  a_r8_err_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> err_o);

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !ready_o));

  a_r9_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b111) |-> (ba_o == '0 && addr_o == '0));

  a_r9_legal_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr || (cmd_o == 3'b111));

  generate
    if (!WIDE_X16) begin : g_narrow
      a_r10_no_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_ext |-> !addr_o[1]);
    end
  endgenerate
endmodule

bind emr_seq emr_seq_chk #(
  .ADDR_W      (ADDR_W),
  .BA_W        (BA_W),
  .WIDE_X16    (WIDE_X16),
  .DLL_RST_BIT (DLL_RST_BIT)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .banks_idle_i (banks_idle_i),
  .burst_busy_i (burst_busy_i),
  .sr_exit_i    (sr_exit_i),
  .cmd_o        (cmd_o),
  .ba_o         (ba_o),
  .addr_o       (addr_o),
  .ready_o      (ready_o),
  .rd_inhibit_o (rd_inhibit_o),
  .err_o        (err_o)
);

// File: tb/test_emr_seq.sv
module test_emr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 13;
  localparam int GAP        = 2;
  localparam int LOCK       = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, dll_off = 1'b0, drv_red = 1'b0;
  logic [AW-1:0] base_mode = '0;
  logic banks_idle = 1'b1, burst_busy = 1'b0, sr_exit = 1'b0;

  logic [2:0] cmd, cmd8;
  logic [1:0] ba, ba8;
  logic [AW-1:0] addr, addr8;
  logic ready, inhibit, err, ready8, inhibit8, err8;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [1:0]    ba;
    logic [AW-1:0] addr;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  emr_seq #(.MRD_GAP(GAP), .LOCK_CYCLES(LOCK), .WIDE_X16(1'b1)) i_emr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dll_off_i(dll_off),
    .drv_reduced_i(drv_red), .base_mode_i(base_mode), .banks_idle_i(banks_idle),
    .burst_busy_i(burst_busy), .sr_exit_i(sr_exit), .cmd_o(cmd), .ba_o(ba),
    .addr_o(addr), .ready_o(ready), .rd_inhibit_o(inhibit), .err_o(err)
  );

  emr_seq #(.MRD_GAP(GAP), .LOCK_CYCLES(LOCK), .WIDE_X16(1'b0)) i_emr_seq_x8 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dll_off_i(dll_off),
    .drv_reduced_i(drv_red), .base_mode_i(base_mode), .banks_idle_i(banks_idle),
    .burst_busy_i(burst_busy), .sr_exit_i(sr_exit), .cmd_o(cmd8), .ba_o(ba8),
    .addr_o(addr8), .ready_o(ready8), .rd_inhibit_o(inhibit8), .err_o(err8)
  );

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // scoreboard monitor
  int cyc = 0;
  int last_lmr = -1;
  always @(negedge clk) begin
    item_t it;
    if (rst_n) begin
      cyc++;
      if (cmd === 3'b000) begin
        if (exp_q.size() == 0) begin
          check("R7", "unexpected load", 32'd1, 32'd0);
        end else begin
          it = exp_q.pop_front();
          check("R5", "load bank", 32'(ba), 32'(it.ba));
          check("R2", "load addr", 32'(addr), 32'(it.addr));
        end
        if (last_lmr >= 0) check("R4", "load spacing", 32'(cyc - last_lmr), 32'(GAP + 1));
        last_lmr = cyc;
        if (ba === 2'b01)
          check("R10", "narrow ext addr", 32'(addr8), 32'(addr & ~13'h2));
      end else begin
        check("R9", "nop bus", {cmd, 13'(ba), addr}, {3'b111, 13'd0, 13'd0});
      end
      if (ready) last_lmr = -1;
    end
  end

  task automatic start_seq(bit off, bit red, logic [AW-1:0] base);
    item_t e;
    e.ba   = 2'b01;
    e.addr = {11'd0, red, off};
    exp_q.push_back(e);
    if (!off) begin
      e.ba   = 2'b00;
      e.addr = base | 13'h100;
      exp_q.push_back(e);
    end
    dll_off   = off;
    drv_red   = red;
    base_mode = base;
    req       = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_inhibit(output int k);
    k = 0;
    while (inhibit && k < 1000) begin
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "reset outputs", {cmd, 13'(ba), addr}, {3'b111, 13'd0, 13'd0});
    check("R1", "reset flags", {ready, inhibit, err}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post reset flags", {ready, inhibit, err}, 3'b100);

    // R2/R6: DLL on, reduced drive, preconditions already met
    start_seq(1'b0, 1'b1, 13'h032);
    check("R2", "hold cycle nop", 32'(cmd), 32'h7);
    check("R2", "busy", 32'(ready), 32'd0);
    @(negedge clk);
    check("R2", "ext load cmd", {cmd, 13'(ba)}, {3'b000, 13'd1});
    check("R6", "no inhibit before load", 32'(inhibit), 32'd0);
    @(negedge clk);
    count_inhibit(k);
    check("R6", "lockout length", 32'(k), 32'(LOCK));
    check("R5", "queue drained", 32'(exp_q.size()), 32'd0);
    check("R5", "ready after dll-on", 32'(ready), 32'd1);

    // R5/R6: DLL off, no base load, no lockout
    start_seq(1'b1, 1'b0, 13'h055);
    wait_ready(n);
    check("R5", "dll-off length", 32'(n), 32'(GAP + 2));
    check("R6", "no lockout on disable", 32'(inhibit), 32'd0);
    check("R5", "no base load", 32'(exp_q.size()), 32'd0);

    // R3 hold-off, then R8 reject while busy
    banks_idle = 1'b0;
    start_seq(1'b0, 1'b0, 13'h062);
    for (int i = 0; i < 4; i++) begin
      check("R3", "held (banks busy)", {cmd, 1'(ready)}, {3'b111, 1'b0});
      @(negedge clk);
    end
    banks_idle = 1'b1;
    burst_busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3", "held (burst)", 32'(cmd), 32'h7);
    end
    burst_busy = 1'b0;
    @(negedge clk);
    check("R3", "issued after release", {cmd, 13'(ba)}, {3'b000, 13'd1});
    dll_off = 1'b1;
    drv_red = 1'b1;
    base_mode = 13'h1fff;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R8", "error pulse", 32'(err), 32'd1);
    @(negedge clk);
    check("R8", "error one cycle", 32'(err), 32'd0);
    wait_ready(n);
    check("R8", "sequence unaffected", 32'(exp_q.size()), 32'd0);
    count_inhibit(k);

    // R5 full DLL-on length
    start_seq(1'b0, 1'b0, 13'h021);
    wait_ready(n);
    check("R5", "dll-on length", 32'(n), 32'(2 * (GAP + 1) + 1));
    count_inhibit(k);

    // R7 self-refresh exit lockout and restart
    sr_exit = 1'b1;
    @(negedge clk);
    sr_exit = 1'b0;
    check("R7", "inhibit after exit", 32'(inhibit), 32'd1);
    repeat (50) @(negedge clk);
    sr_exit = 1'b1;
    @(negedge clk);
    sr_exit = 1'b0;
    count_inhibit(k);
    check("R7", "restarted lockout length", 32'(k), 32'(LOCK));
    check("R7", "still ready", 32'(ready), 32'd1);

    repeat (5) @(negedge clk);
    check("R5", "final queue", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule